// File: doc/BRIEF.md
# Retention-Binned Row Refresh Scheduler

This block replaces the single worst-case refresh rate with rates chosen row by row. Weak rows are recorded in one of two Bloom-filter bins. The fast bin holds rows that need a refresh every base period, and the middle bin holds rows that need one every second period. Any row found in neither bin is refreshed once every four base periods. Once per base period a row pointer walks the whole address space. For each row the block probes both filters, one cycle per filter, and decides whether the row is due in the current pass. A due row is handed to the command arbiter as an activate request followed by a precharge request on the same row, each through a valid/ready handshake.

Software or a profiling engine loads the bins through an insert port, which takes a row address and a bin select. A filter can report a row it never received, which only makes that row refresh more often than it needs to. It can never miss a row it did receive. Inserting rows never overflows a filter. Both filters empty only on reset or on the clear input.

The block keeps a 2-bit pass index that advances at every pass start and beginning at 0 after reset. In a pass with index 0 every row is due. A middle-bin row is due when the index is even, and a fast-bin row is due in every pass. A stall on the ready input holds the current request and the row pointer.

Top module: `rowbin_refresh`

## Requirements
- R1: While reset is asserted no request is valid. The first pass after reset has index 0 and refreshes every row.
- R2: Within a pass, rows are issued in strictly ascending address order, and each row at most once.
- R3: A row inserted with ins_bin=0 (fast bin) is refreshed in every pass.
- R4: A row inserted with ins_bin=1 (middle bin) is refreshed in every pass whose index is even (0 or 2).
- R5: With both filters empty, only passes with index 0 issue requests. Passes with index 1, 2 and 3 issue none.
- R6: Each refresh is an activate request (ref_pre=0) followed by a precharge request (ref_pre=1) for the same row. The precharge is valid in the cycle after the activate is accepted, and a new request always starts with an activate.
- R7: While ref_valid is high and ref_ready is low, ref_valid, ref_row and ref_pre hold their values.
- R8: Asserting flt_clr for one cycle empties both filters, so later passes behave as in R5.
- R9: A new pass begins every PERIOD clock cycles, and the pass index counts 0,1,2,3 and wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_clr | input | 1 | Clears both filters |
| ins_valid | input | 1 | Insert a row into a bin this cycle |
| ins_bin | input | 1 | 0 selects the fast bin, 1 the middle bin |
| ins_row | input | ROW_W | Row address to insert |
| ref_valid | output | 1 | Refresh request valid |
| ref_ready | input | 1 | Arbiter accepts the request |
| ref_row | output | ROW_W | Row of the request |
| ref_pre | output | 1 | 0 for activate, 1 for precharge |

## Verification
The hardest situation to reach is a pass whose index is 2 while the middle bin holds rows and the fast bin holds others. Only that pass separates the middle-bin rate from both the fast and the default rates. The stimulus runs eleven passes with a short period. It inserts one fast-bin row and two middle-bin rows during an idle pass, so passes 4 to 7 walk through all four index values with populated filters. The filters are then cleared, and the following index-1 and index-2 passes must stay silent. A long ready stall inside a full pass checks that the held request survives and that the pass still completes.

// File: rtl/rowbin_refresh.sv
module rowbin_refresh #(
  parameter int ROW_W     = 16,
  parameter int PERIOD    = 64_000_000,
  parameter int BITS_FAST = 2048,
  parameter int HASH_FAST = 10,
  parameter int BITS_MID  = 8192,
  parameter int HASH_MID  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flt_clr,
  input  logic             ins_valid,
  input  logic             ins_bin,
  input  logic [ROW_W-1:0] ins_row,
  output logic             ref_valid,
  input  logic             ref_ready,
  output logic [ROW_W-1:0] ref_row,
  output logic             ref_pre
);
  localparam int FW = $clog2(BITS_FAST);
  localparam int MW = $clog2(BITS_MID);
  localparam int TW = $clog2(PERIOD);

  typedef enum logic [2:0] {IDLE, PRB_F, PRB_M, ACT, PRE} st_t;

  function automatic logic [31:0] seed(int fn, int b);
    logic [31:0] x;
    x = 32'(fn * 64 + b + 1) * 32'h9E3779B1;
    x = x ^ (x >> 15);
    x = x * 32'h85EBCA77;
    x = x ^ (x >> 13);
    return x;
  endfunction

  function automatic logic [31:0] h3(logic [31:0] r, int fn);
    logic [31:0] o;
    for (int b = 0; b < 32; b++) o[b] = ^(r & seed(fn, b));
    return o;
  endfunction

  st_t                  state;
  logic [1:0]           idx;
  logic                 pend, hit_fast_q, hit_fast, hit_mid, due, last;
  logic [TW-1:0]        tcnt;
  logic [BITS_FAST-1:0] fast_q;
  logic [BITS_MID-1:0]  mid_q;
  wire                  wrap = (tcnt == TW'(PERIOD - 1));

  always_comb begin
    hit_fast = 1'b1;
    for (int k = 0; k < HASH_FAST; k++)
      hit_fast &= fast_q[FW'(h3(32'(ref_row), k))];
    hit_mid = 1'b1;
    for (int k = 0; k < HASH_MID; k++)
      hit_mid &= mid_q[MW'(h3(32'(ref_row), 16 + k))];
  end

  assign due       = (idx == 2'd0) | hit_fast_q | (hit_mid & ~idx[0]);
  assign last      = &ref_row;
  assign ref_valid = (state == ACT) || (state == PRE);
  assign ref_pre   = (state == PRE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fast_q <= '0;
      mid_q  <= '0;
    end else if (flt_clr) begin
      fast_q <= '0;
      mid_q  <= '0;
    end else if (ins_valid) begin
      if (!ins_bin)
        for (int k = 0; k < HASH_FAST; k++) fast_q[FW'(h3(32'(ins_row), k))] <= 1'b1;
      else
        for (int k = 0; k < HASH_MID; k++) mid_q[MW'(h3(32'(ins_row), 16 + k))] <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tcnt <= '0;
      pend <= 1'b1;
    end else begin
      tcnt <= wrap ? '0 : tcnt + 1'b1;
      pend <= wrap | (pend & (state != IDLE));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state      <= IDLE;
      ref_row    <= '0;
      idx        <= 2'd3;
      hit_fast_q <= 1'b0;
    end else begin
      case (state)
        IDLE: if (pend) begin
          state   <= PRB_F;
          ref_row <= '0;
          idx     <= idx + 2'd1;
        end
        PRB_F: begin
          hit_fast_q <= hit_fast;
          state      <= PRB_M;
        end
        PRB_M: begin
          if (due)       state <= ACT;
          else if (last) state <= IDLE;
          else begin
            ref_row <= ref_row + 1'b1;
            state   <= PRB_F;
          end
        end
        ACT: if (ref_ready) state <= PRE;
        PRE: if (ref_ready) begin
          if (last) state <= IDLE;
          else begin
            ref_row <= ref_row + 1'b1;
            state   <= PRB_F;
          end
        end
        default: state <= IDLE;
      endcase
    end
endmodule

// File: rtl/rowbin_refresh_chk.sv
module rowbin_refresh_chk #(
  parameter int ROW_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_valid,
  input logic             ref_ready,
  input logic [ROW_W-1:0] ref_row,
  input logic             ref_pre
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> !ref_valid);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid && !ref_ready |=> ref_valid && $stable(ref_row) && $stable(ref_pre));

  // R6
  act_pre_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid && ref_ready && !ref_pre |=> ref_valid && ref_pre && $stable(ref_row));

  // R6
  new_req_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_valid) |-> !ref_pre);

  // R6
  pre_then_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid && ref_ready && ref_pre |=> !ref_valid || !ref_pre);
endmodule

bind rowbin_refresh rowbin_refresh_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_ready(ref_ready),
  .ref_row(ref_row), .ref_pre(ref_pre)
);

// File: tb/test_rowbin_refresh.sv
`timescale 1ns/100ps
module test_rowbin_refresh;
  localparam int RW = 5;
  localparam int P  = 256;
  localparam int NP = 11;

  // {exact, expected row mask}
  localparam logic [32:0] VEC [NP] = '{
    {1'b1, 32'hFFFF_FFFF}, {1'b1, 32'h0}, {1'b1, 32'h0}, {1'b1, 32'h0},
    {1'b1, 32'hFFFF_FFFF}, {1'b0, 32'h0000_0020}, {1'b0, 32'h0010_0220},
    {1'b0, 32'h0000_0020}, {1'b1, 32'hFFFF_FFFF}, {1'b1, 32'h0}, {1'b1, 32'h0}
  };
  localparam string TAG [NP] = '{"R1", "R5", "R5", "R5", "R9", "R3", "R4", "R3",
                                 "R7", "R8", "R8"};

  logic clk = 0, rst_n = 1, flt_clr = 0, ins_valid = 0, ins_bin = 0, ref_ready = 1;
  logic [RW-1:0] ins_row = '0;
  logic ref_valid, ref_pre;
  logic [RW-1:0] ref_row;

  rowbin_refresh #(.ROW_W(RW), .PERIOD(P)) i_rowbin_refresh (
    .clk(clk), .rst_n(rst_n), .flt_clr(flt_clr), .ins_valid(ins_valid),
    .ins_bin(ins_bin), .ins_row(ins_row), .ref_valid(ref_valid),
    .ref_ready(ref_ready), .ref_row(ref_row), .ref_pre(ref_pre)
  );

  always #2.5 clk = ~clk;

  int cyc = 0, n_cmp = 0, n_bad = 0, lpass = -1, mp;
  logic [31:0] seen [12];
  int perr [12];
  logic open_f = 0, have_l = 0, done = 0;
  logic [RW-1:0] orow, lrow;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  always @(negedge clk)
    if (rst_n && ref_valid && ref_ready) begin
      mp = cyc / P;
      if (mp < 12) begin
        if (mp != lpass) begin have_l = 0; lpass = mp; end
        if (!ref_pre) begin
          if (open_f || (have_l && ref_row <= lrow)) perr[mp]++;
          open_f = 1; orow = ref_row;
        end else begin
          if (!open_f || ref_row != orow) perr[mp]++;
          open_f = 0; seen[mp][ref_row] = 1'b1; lrow = ref_row; have_l = 1;
        end
      end
    end

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic insert(input logic bin, input logic [RW-1:0] row);
    ins_valid = 1; ins_bin = bin; ins_row = row;
    @(negedge clk);
    ins_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < 12; i++) begin seen[i] = '0; perr[i] = 0; end
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    check(ref_valid == 1'b0, "R1", "valid during reset", 32'(ref_valid), 32'h0);
    rst_n = 1;
    for (int v = 0; v < NP; v++) begin
      logic [31:0] exp;
      logic ok;
      wait_until((v + 1) * P);
      exp = VEC[v][31:0];
      ok  = VEC[v][32] ? (seen[v] == exp) : ((seen[v] & exp) == exp);
      check(ok, TAG[v], $sformatf("row mask of pass %0d", v), seen[v], exp);
      check(perr[v] == 0, "R2,R6", $sformatf("order/pairing errors pass %0d", v),
            32'(perr[v]), 32'h0);
    end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [RW-1:0] r0;
    wait_until(3 * P + 200);
    insert(1'b0, 5'd5);
    insert(1'b1, 5'd9);
    insert(1'b1, 5'd20);
    wait_until(7 * P + 200);
    flt_clr = 1;
    @(negedge clk);
    flt_clr = 0;
    wait_until(8 * P + 20);
    ref_ready = 0;
    repeat (4) @(negedge clk);
    r0 = ref_row;
    check(ref_valid == 1'b1, "R7", "valid raised under stall", 32'(ref_valid), 32'h1);
    repeat (40) @(negedge clk);
    check(ref_valid && ref_row == r0, "R7", "request held under stall",
          {ref_valid, 26'(0), ref_row}, {1'b1, 26'(0), r0});
    ref_ready = 1;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual %0d expected %0d", cyc, NP * P);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule